// File: doc/BRIEF.md
# Peripheral Request Router with Group-Priority Arbiter

This block sits between a set of peripheral request lines and a bank of DMA channels. Each request line owns a small map register. The register names a target channel and carries a valid flag. Every asserted line whose map is valid raises the request of the channel it names. Several lines may point at one channel, and their requests are merged.

A registered arbiter then chooses one requesting channel per cycle. Channels belong to four fixed priority groups, taken from bits 3:2 of the channel index. A group is served only while every more urgent group is idle, and the channels inside one group take turns. The block also carries two per-channel words. One is a byte-alignment enable word that software can write. The other is a read-only interrupt summary that mirrors each channel's interrupt status. Data movement is not part of this block.

Top module: `prr_top`

## Requirements
- R1: After reset every map entry is invalid and reads as 0, and `ch_req`, `byte_align`, `irq_summary` and `grant_valid` are all 0.
- R2: A map register keeps bit 7 as the valid flag and bits 4:0 as the target channel. Readback shows exactly these bits, and every other bit reads as 0.
- R3: The map register for line n is at byte address 0x100 + 4·n when n < 64. For n ≥ 64 it is at 0x1100 + 4·(n − 64).
- R4: When a line is asserted and its map is valid, the named channel's bit in `ch_req` is 1 one clock edge later.
- R5: A line whose map is invalid has no effect on `ch_req`. This includes a map that was written with zero.
- R6: When two valid maps name the same channel, that channel requests while either of the two lines is asserted.
- R7: The priority group of channel c is (c & 15) >> 2, and group 0 is the most urgent. The arbiter grants a channel of a lower group only when no channel of a higher group is requesting.
- R8: Inside one group, requesting channels are granted in turn. A channel granted in one cycle is not granted again in the next cycle while another channel of the same group is requesting.
- R9: The summary word at 0x044 has bit c equal to channel c's interrupt input, one edge after that input is sampled. The word is driven on `irq_summary`, and writes to it have no effect.
- R10: The alignment word at 0x040 can be written and read, one bit per channel, and it drives `byte_align`.
- R11: `grant_valid` and `grant_ch` change one edge after `ch_req` does. `grant_valid` is 0 exactly when `ch_req` was all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 13 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational from `cfg_addr`) |
| periph_req | input | N_REQ | Peripheral request lines |
| ch_irq | input | N_CH | Per-channel interrupt status |
| ch_req | output | N_CH | Routed per-channel requests |
| byte_align | output | N_CH | Per-channel byte-alignment enable |
| irq_summary | output | N_CH | Registered interrupt summary |
| grant_valid | output | 1 | A channel is granted this cycle |
| grant_ch | output | CH_W | Index of the granted channel |

## Verification
A corrupted map entry shows up on `ch_req` one edge after the line it affects is driven. It also appears straight away on register readback, because the read path is combinational. A wrong group pointer or level decode shows on `grant_ch` two edges after the request line changes. Round-robin faults show as the same channel being granted twice in a row while a peer in its group is waiting. A stale summary register differs from `ch_irq` one edge after that input changes.

// File: rtl/prr_pkg.sv
package prr_pkg;
    localparam int ADDR_W = 13;
    localparam logic [ADDR_W-1:0] LO_BASE   = 13'h0100;
    localparam logic [ADDR_W-1:0] HI_BASE   = 13'h1100;
    localparam logic [ADDR_W-1:0] ALIGN_OFS = 13'h0040;
    localparam logic [ADDR_W-1:0] SUM_OFS   = 13'h0044;

    typedef struct packed {
        logic       valid;
        logic [4:0] ch;
    } map_ent_t;

    function automatic logic [ADDR_W-1:0] map_addr(input int unsigned n);
        if (n < 64) return LO_BASE + ADDR_W'(4 * n);
        else        return HI_BASE + ADDR_W'(4 * (n - 64));
    endfunction

    function automatic logic [1:0] prio_level(input int unsigned idx);
        return 2'((idx & 15) >> 2);
    endfunction
endpackage

// File: rtl/prr_regs.sv
module prr_regs
    import prr_pkg::*;
#(
    parameter int N_REQ = 80,
    parameter int N_CH  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    input  logic [N_CH-1:0]       irq_i,
    output logic [31:0]           rdata,
    output map_ent_t [N_REQ-1:0]  map_o,
    output logic [N_CH-1:0]       align_o,
    output logic [N_CH-1:0]       sum_o
);
    typedef struct packed {
        map_ent_t [N_REQ-1:0] map;
        logic [N_CH-1:0]      align;
        logic [N_CH-1:0]      sum;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.sum = irq_i;
        if (we) begin
            for (int n = 0; n < N_REQ; n++) begin
                if (addr == map_addr(n)) begin
                    s_d.map[n].valid = wdata[7];
                    s_d.map[n].ch    = wdata[4:0];
                end
            end
            if (addr == ALIGN_OFS) s_d.align = wdata[N_CH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        for (int n = 0; n < N_REQ; n++)
            if (addr == map_addr(n))
                rdata = {24'h0, s_q.map[n].valid, 2'b00, s_q.map[n].ch};
        if (addr == ALIGN_OFS) rdata = 32'(s_q.align);
        if (addr == SUM_OFS)   rdata = 32'(s_q.sum);
    end

    assign map_o   = s_q.map;
    assign align_o = s_q.align;
    assign sum_o   = s_q.sum;

    a_r9_summary_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sum_o == $past(irq_i)));
    a_r5_zero_write_unmaps: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == LO_BASE && wdata == 32'h0) |=> !map_o[0].valid);
endmodule

// File: rtl/prr_router.sv
module prr_router
    import prr_pkg::*;
#(
    parameter int N_REQ = 80,
    parameter int N_CH  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  map_ent_t [N_REQ-1:0]  map_i,
    input  logic [N_REQ-1:0]      req_i,
    output logic [N_CH-1:0]       ch_req_o
);
    typedef struct packed {
        logic [N_CH-1:0] ch_req;
    } st_t;

    st_t s_d, s_q;
    logic [N_REQ-1:0] live;

    // A line contributes only while its map entry is valid.
    generate
        for (genvar n = 0; n < N_REQ; n++) begin : g_live
            assign live[n] = req_i[n] & map_i[n].valid;
        end
    endgenerate

    always_comb begin
        s_d = '0;
        for (int n = 0; n < N_REQ; n++)
            for (int c = 0; c < N_CH; c++)
                if (live[n] && int'(map_i[n].ch) == c) s_d.ch_req[c] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ch_req_o = s_q.ch_req;

    a_r5_idle_lines_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> (ch_req_o == '0));
    a_r4_request_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_req_o != '0) |-> $past(req_i != '0));
endmodule

// File: rtl/prr_arbiter.sv
module prr_arbiter
    import prr_pkg::*;
#(
    parameter int N_CH = 32,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] req_i,
    output logic            gnt_valid_o,
    output logic [CH_W-1:0] gnt_ch_o
);
    typedef struct packed {
        logic [3:0][CH_W-1:0] ptr;
        logic [N_CH-1:0]      gvec;
        logic                 valid;
        logic [CH_W-1:0]      ch;
    } st_t;

    st_t s_d, s_q;
    logic [3:0][N_CH-1:0] lvl_mask;
    logic [3:0]           lvl_hit;
    logic [1:0]           sel;
    logic [N_CH-1:0]      cand;
    logic                 found;
    int                   pick;
    int                   idx;

    generate
        for (genvar l = 0; l < 4; l++) begin : g_lvl
            for (genvar c = 0; c < N_CH; c++) begin : g_ch
                assign lvl_mask[l][c] = (prio_level(c) == 2'(l));
            end
            assign lvl_hit[l] = |(req_i & lvl_mask[l]);
        end
    endgenerate

    always_comb begin
        sel = 2'd0;
        for (int l = 3; l >= 0; l--)
            if (lvl_hit[l]) sel = 2'(l);
        cand  = req_i & lvl_mask[sel];
        found = 1'b0;
        pick  = 0;
        idx   = 0;
        for (int j = 1; j <= N_CH; j++) begin
            idx = (int'(s_q.ptr[sel]) + j) % N_CH;
            if (!found && cand[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
        s_d       = s_q;
        s_d.gvec  = '0;
        s_d.valid = found;
        if (found) begin
            s_d.gvec[pick] = 1'b1;
            s_d.ptr[sel]   = CH_W'(pick);
            s_d.ch         = CH_W'(pick);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ptr   <= {4{CH_W'(N_CH - 1)}};
        end else begin
            s_q <= s_d;
        end
    end

    assign gnt_valid_o = s_q.valid;
    assign gnt_ch_o    = s_q.ch;

    a_r11_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> !gnt_valid_o);
    a_r11_busy_grants: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |=> gnt_valid_o);
    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.gvec));
    a_r7_granted_was_requesting: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.gvec & ~$past(req_i)) == '0));
endmodule

// File: rtl/prr_top.sv
module prr_top
    import prr_pkg::*;
#(
    parameter int N_REQ = 80,
    parameter int N_CH  = 32,
    localparam int CH_W = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [12:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [N_REQ-1:0]  periph_req,
    input  logic [N_CH-1:0]   ch_irq,
    output logic [N_CH-1:0]   ch_req,
    output logic [N_CH-1:0]   byte_align,
    output logic [N_CH-1:0]   irq_summary,
    output logic              grant_valid,
    output logic [CH_W-1:0]   grant_ch
);
    map_ent_t [N_REQ-1:0] map_w;

    prr_regs #(.N_REQ(N_REQ), .N_CH(N_CH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .irq_i   (ch_irq),
        .rdata   (cfg_rdata),
        .map_o   (map_w),
        .align_o (byte_align),
        .sum_o   (irq_summary)
    );

    prr_router #(.N_REQ(N_REQ), .N_CH(N_CH)) u_router (
        .clk      (clk),
        .rst_n    (rst_n),
        .map_i    (map_w),
        .req_i    (periph_req),
        .ch_req_o (ch_req)
    );

    prr_arbiter #(.N_CH(N_CH)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (ch_req),
        .gnt_valid_o (grant_valid),
        .gnt_ch_o    (grant_ch)
    );
endmodule

// File: tb/sim_prr_top.sv
module sim_prr_top;
    localparam int NR = 80;
    localparam int NC = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [12:0]   cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NR-1:0] periph_req = '0;
    logic [NC-1:0] ch_irq = '0;
    logic [NC-1:0] ch_req, byte_align, irq_summary;
    logic          grant_valid;
    logic [4:0]    grant_ch;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prr_top #(.N_REQ(NR), .N_CH(NC)) u0 (.*);

    typedef struct packed {
        logic [12:0] a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    // R2/R3/R9/R10 write-then-read vectors
    localparam vec_t TBL [8] = '{
        '{13'h0100, 32'h0000_0083, 32'h0000_0083},
        '{13'h0114, 32'hFFFF_FF9F, 32'h0000_009F},
        '{13'h01FC, 32'h0000_0080, 32'h0000_0080},
        '{13'h1100, 32'h0000_0091, 32'h0000_0091},
        '{13'h113C, 32'h0000_0084, 32'h0000_0084},
        '{13'h0108, 32'h0000_007F, 32'h0000_001F},
        '{13'h0040, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{13'h0044, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic drive(input logic [NR-1:0] r, input int waits);
        @(negedge clk);
        periph_req = r;
        repeat (waits) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [4:0]  g1, g2, g3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ch_req", 32'(ch_req), 32'h0);
        chk("R1 grant_valid", 32'(grant_valid), 32'h0);
        chk("R1 byte_align", 32'(byte_align), 32'h0);
        chk("R1 irq_summary", 32'(irq_summary), 32'h0);
        rd(13'h0100, v); chk("R1 map lo", v, 32'h0);
        rd(13'h1100, v); chk("R1 map hi", v, 32'h0);

        // table walk: R2 R3 R9 R10
        for (int i = 0; i < 8; i++) begin
            wr(TBL[i].a, TBL[i].w);
            rd(TBL[i].a, v);
            chk("R2/R3/R9/R10 readback", v, TBL[i].e);
        end
        chk("R10 byte_align", 32'(byte_align), 32'hDEAD_BEEF);
        rd(13'h0104, v); chk("R3 unwritten neighbour", v, 32'h0);

        // maps: line0->3, line5->31, line63->0, line64->17, line79->4, line2 invalid
        drive(80'h1, 1);               chk("R4 line0 to ch3", 32'(ch_req), 32'h0000_0008);
        drive(80'h1 << 79, 1);         chk("R4 R3 line79 to ch4", 32'(ch_req), 32'h0000_0010);
        drive(80'h1 << 64, 1);         chk("R3 line64 to ch17", 32'(ch_req), 32'h0002_0000);
        drive(80'h1 << 63, 1);         chk("R3 line63 to ch0", 32'(ch_req), 32'h0000_0001);
        drive(80'h4, 1);               chk("R5 invalid line2", 32'(ch_req), 32'h0);
        drive(80'h24, 1);              chk("R5 line5 only ch31", 32'(ch_req), 32'h8000_0000);
        drive(80'h0, 2);               chk("R11 idle no grant", 32'(grant_valid), 32'h0);

        // R6 second line onto ch3
        wr(13'h0118, 32'h83);
        drive(80'h40, 1);              chk("R6 line6 to ch3", 32'(ch_req), 32'h0000_0008);
        drive(80'h41, 1);              chk("R6 merged ch3", 32'(ch_req), 32'h0000_0008);
        wr(13'h0100, 32'h0);
        drive(80'h1, 1);               chk("R5 zero write unmaps", 32'(ch_req), 32'h0);
        drive(80'h0, 2);

        // arbiter: line10->1, 11->17, 12->8, 13->12, 14->4
        wr(13'h0128, 32'h81);
        wr(13'h012C, 32'h91);
        wr(13'h0130, 32'h88);
        wr(13'h0134, 32'h8C);
        wr(13'h0138, 32'h84);
        @(negedge clk);
        periph_req = 80'h1 << 13;
        @(negedge clk);
        chk("R11 grant lags ch_req", 32'(grant_valid), 32'h0);
        @(negedge clk);
        chk("R11 grant after ch_req", 32'(grant_ch), 32'd12);
        drive(80'h3 << 12, 3);         chk("R7 level2 over level3", 32'(grant_ch), 32'd8);
        @(negedge clk);                chk("R7 level2 holds", 32'(grant_ch), 32'd8);
        drive(80'h7 << 12, 3);         chk("R7 level1 over level2", 32'(grant_ch), 32'd4);
        drive(80'h1F << 10, 3);
        g1 = grant_ch;
        @(negedge clk); g2 = grant_ch;
        @(negedge clk); g3 = grant_ch;
        chk("R7 level0 wins", 32'((g1 == 5'd1) || (g1 == 5'd17)), 32'h1);
        chk("R8 turn passes", 32'(g2), (g1 == 5'd1) ? 32'd17 : 32'd1);
        chk("R8 turn returns", 32'(g3), 32'(g1));
        drive(80'h0, 2);               chk("R11 grant drops", 32'(grant_valid), 32'h0);

        // R9 summary follows irq, writes ignored
        @(negedge clk); ch_irq = 32'h0001_0020;
        @(negedge clk);
        chk("R9 summary port", 32'(irq_summary), 32'h0001_0020);
        wr(13'h0044, 32'h0);
        rd(13'h0044, v);               chk("R9 summary write ignored", v, 32'h0001_0020);
        @(negedge clk); ch_irq = '0;
        @(negedge clk);
        chk("R9 summary clears", 32'(irq_summary), 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule